// File: doc/BRIEF.md
# Conditional Execution Predicate Unit

This block decides, every cycle, whether the instruction currently presented may commit. It compares a 4-bit condition code against the stored negative, zero, carry and overflow flags and drives an execute-enable. The same decision gates the write of the destination register and the flag writeback.

The unit also owns the processor flag register. The negative, zero, carry and overflow bits are loaded from an external ALU. A load happens only when the instruction asks for a flag update and its condition holds. A fifth, sticky saturation bit is set by a saturating operation that executes. Ordinary flag loads leave it alone, and only a dedicated clear input resets it. Compare-type operations update the flags but never write a destination register.

Top module: `condPredUnit`

## Requirements
- R1: After reset, all five stored flags (flagNzcv = {N,Z,C,V} and flagQ) are 0.
- R2: The simple conditions are decoded with these codes. EQ=0000 is true when Z=1, and NE=0001 is true when Z=0. CS=0010 is true when C=1, and CC=0011 is true when C=0. MI=0100 is true when N=1, and PL=0101 is true when N=0. VS=0110 is true when V=1, and VC=0111 is true when V=0.
- R3: HI=1000 is true when C=1 and Z=0. LS=1001 is its inverse.
- R4: GE=1010 is true when N equals V, and LT=1011 is its inverse. GT=1100 is true when Z=0 and N equals V, and LE=1101 is its inverse.
- R5: Code 1110 always executes, and code 1111 never executes.
- R6: execEn depends combinationally on the flags held at the start of the cycle. When setFlags is 1 and the condition holds, flagNzcv takes {aluN,aluZ,aluC,aluV} at the next clock edge.
- R7: When setFlags is 1 and the condition fails, the flags are unchanged and destWrite is 0.
- R8: When setFlags is 0, flagNzcv is unchanged, whatever the ALU flag inputs are.
- R9: destWrite equals execEn when isCompare is 0, and destWrite is always 0 when isCompare is 1. A compare that has setFlags and passes its condition still loads the flags.
- R10: satIn on an instruction whose condition passes sets flagQ at the next edge. After that, flagQ stays 1 through any flag load until it is cleared.
- R11: qClear clears flagQ at the next edge. If satIn arrives in the same cycle, qClear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| condCode | input | 4 | Condition field of the current instruction |
| setFlags | input | 1 | Instruction requests a flag update |
| isCompare | input | 1 | Instruction is a compare (no destination write) |
| satIn | input | 1 | Saturating operation saturated this cycle |
| qClear | input | 1 | Explicit clear of the saturation bit |
| aluN | input | 1 | Negative result from the ALU |
| aluZ | input | 1 | Zero result from the ALU |
| aluC | input | 1 | Carry result from the ALU |
| aluV | input | 1 | Overflow result from the ALU |
| execEn | output | 1 | Condition passes; the instruction may commit |
| destWrite | output | 1 | Destination register write enable |
| flagNzcv | output | 4 | Stored {N,Z,C,V} |
| flagQ | output | 1 | Stored sticky saturation bit |

## Verification
execEn and destWrite are combinational, so they are due in the same cycle as the condition code. The bench drives the code on a falling edge and samples one nanosecond later, before the next rising edge. Flag and saturation updates are due one rising edge after the stimulus. The bench therefore commits them at that edge, removes the stimulus and reads the flags at the following falling edge. The bench loads each of the sixteen flag combinations in turn and, for each one, sweeps all sixteen condition codes against an arithmetic model of the predicate.

// File: rtl/condPredPkg.sv
package condPredPkg;
  localparam int NZCV_W  = 4;
  localparam int COND_W  = 4;

  typedef enum logic [COND_W-1:0] {
    CND_EQ = 4'b0000, CND_NE = 4'b0001,
    CND_CS = 4'b0010, CND_CC = 4'b0011,
    CND_MI = 4'b0100, CND_PL = 4'b0101,
    CND_VS = 4'b0110, CND_VC = 4'b0111,
    CND_HI = 4'b1000, CND_LS = 4'b1001,
    CND_GE = 4'b1010, CND_LT = 4'b1011,
    CND_GT = 4'b1100, CND_LE = 4'b1101,
    CND_AL = 4'b1110, CND_NV = 4'b1111
  } condT;

  typedef struct packed {
    logic nzcvLoad;
    logic qSet;
    logic qClr;
  } flagStrobeT;
endpackage

// File: rtl/condPredCtrl.sv
module condPredCtrl
  import condPredPkg::*;
(
  input  logic [COND_W-1:0] condCode,
  input  logic [NZCV_W-1:0] curNzcv,
  input  logic              setFlags,
  input  logic              isCompare,
  input  logic              satIn,
  input  logic              qClear,
  output logic              execEn,
  output logic              destWrite,
  output flagStrobeT        strobes
);
  logic fN, fZ, fC, fV;
  logic pass;
  logic hiTerm, geTerm, gtTerm;

  assign {fN, fZ, fC, fV} = curNzcv;
  assign hiTerm = fC & ~fZ;
  assign geTerm = ~(fN ^ fV);
  assign gtTerm = ~fZ & geTerm;

  always_comb begin
    unique case (condT'(condCode))
      CND_EQ: pass = fZ;
      CND_NE: pass = ~fZ;
      CND_CS: pass = fC;
      CND_CC: pass = ~fC;
      CND_MI: pass = fN;
      CND_PL: pass = ~fN;
      CND_VS: pass = fV;
      CND_VC: pass = ~fV;
      CND_HI: pass = hiTerm;
      CND_LS: pass = ~hiTerm;
      CND_GE: pass = geTerm;
      CND_LT: pass = ~geTerm;
      CND_GT: pass = gtTerm;
      CND_LE: pass = ~gtTerm;
      CND_AL: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  assign execEn           = pass;
  assign destWrite        = pass & ~isCompare;
  assign strobes.nzcvLoad = pass & setFlags;
  assign strobes.qSet     = pass & satIn;
  assign strobes.qClr     = qClear;
endmodule

// File: rtl/condPredFlags.sv
module condPredFlags
  import condPredPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  flagStrobeT        strobes,
  input  logic [NZCV_W-1:0] aluNzcv,
  output logic [NZCV_W-1:0] nzcvQ,
  output logic              satQ
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nzcvQ <= '0;
      satQ  <= 1'b0;
    end else begin
      if (strobes.nzcvLoad) nzcvQ <= aluNzcv;
      if (strobes.qClr)      satQ <= 1'b0;
      else if (strobes.qSet) satQ <= 1'b1;
    end
  end
endmodule

// File: rtl/condPredUnit.sv
module condPredUnit
  import condPredPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  condCode,
  input  logic        setFlags,
  input  logic        isCompare,
  input  logic        satIn,
  input  logic        qClear,
  input  logic        aluN,
  input  logic        aluZ,
  input  logic        aluC,
  input  logic        aluV,
  output logic        execEn,
  output logic        destWrite,
  output logic [3:0]  flagNzcv,
  output logic        flagQ
);
  flagStrobeT strobes;

  condPredCtrl u_ctrl (
    .condCode  (condCode),
    .curNzcv   (flagNzcv),
    .setFlags  (setFlags),
    .isCompare (isCompare),
    .satIn     (satIn),
    .qClear    (qClear),
    .execEn    (execEn),
    .destWrite (destWrite),
    .strobes   (strobes)
  );

  condPredFlags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .aluNzcv ({aluN, aluZ, aluC, aluV}),
    .nzcvQ   (flagNzcv),
    .satQ    (flagQ)
  );
endmodule

// File: rtl/condPredUnitChk.sv
module condPredUnitChk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] condCode,
  input logic       setFlags,
  input logic       isCompare,
  input logic       satIn,
  input logic       qClear,
  input logic       aluN,
  input logic       aluZ,
  input logic       aluC,
  input logic       aluV,
  input logic       execEn,
  input logic       destWrite,
  input logic [3:0] flagNzcv,
  input logic       flagQ
);
  a_r5_always: assert property (@(posedge clk) disable iff (!rst_n)
    (condCode == 4'b1110) |-> execEn);
  a_r5_never: assert property (@(posedge clk) disable iff (!rst_n)
    (condCode == 4'b1111) |-> !execEn);
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    (setFlags && execEn) |=> (flagNzcv == $past({aluN, aluZ, aluC, aluV})));
  a_r7_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (setFlags && !execEn) |=> $stable(flagNzcv));
  a_r8_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !setFlags |=> $stable(flagNzcv));
  a_r9_cmp_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    isCompare |-> !destWrite);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flagQ && !qClear) |=> flagQ);
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    qClear |=> !flagQ);
endmodule

bind condPredUnit condPredUnitChk u_chk (.*);

// File: tb/condPredUnit_tb.sv
module condPredUnit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] condCode;
  logic       setFlags, isCompare, satIn, qClear;
  logic       aluN, aluZ, aluC, aluV;
  logic       execEn, destWrite, flagQ;
  logic [3:0] flagNzcv;

  int nRun  = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  condPredUnit u_dut (.*);

  function automatic logic refPass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c && !z;
      3'd5: base = (n == v);
      3'd6: base = !z && (n == v);
      default: base = 1'b1;
    endcase
    if (cc == 4'hF) return 1'b0;
    if (cc == 4'hE) return 1'b1;
    return cc[0] ? !base : base;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    setFlags = 0; isCompare = 0; satIn = 0; qClear = 0;
    condCode = 4'hE; {aluN, aluZ, aluC, aluV} = 4'h0;
  endtask

  // drive one cycle of stimulus from a falling edge, commit at rising edge
  task automatic step(input logic [3:0] cc, input logic sf, input logic cmp,
                      input logic sat, input logic clr, input logic [3:0] alu);
    @(negedge clk);
    condCode = cc; setFlags = sf; isCompare = cmp; satIn = sat; qClear = clr;
    {aluN, aluZ, aluC, aluV} = alu;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic loadFlags(input logic [3:0] f);
    step(4'hE, 1'b1, 1'b0, 1'b0, 1'b0, f);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    @(negedge clk);
    check("R1 nzcv", flagNzcv, 0);
    check("R1 q", flagQ, 0);

    // exhaustive predicate sweep: R2 R3 R4 R5 and R6 load path
    for (int f = 0; f < 16; f++) begin
      loadFlags(f[3:0]);
      @(negedge clk);
      check("R6 load", flagNzcv, f);
      for (int cc = 0; cc < 16; cc++) begin
        condCode = cc[3:0];
        #1;
        if (cc < 8)       check("R2 cond", execEn, refPass(cc[3:0], f[3:0]));
        else if (cc < 10) check("R3 cond", execEn, refPass(cc[3:0], f[3:0]));
        else if (cc < 14) check("R4 cond", execEn, refPass(cc[3:0], f[3:0]));
        else              check("R5 cond", execEn, refPass(cc[3:0], f[3:0]));
        @(negedge clk);
      end
    end

    // R7: flags = Z set; NE fails, setFlags must not load
    loadFlags(4'b0100);
    @(negedge clk);
    condCode = 4'h1; setFlags = 1; {aluN, aluZ, aluC, aluV} = 4'b1011;
    #1 check("R7 destWrite", destWrite, 0);
    @(posedge clk); #1 idle();
    @(negedge clk);
    check("R7 hold", flagNzcv, 4'b0100);

    // R8: passing condition, no set request
    step(4'hE, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111);
    @(negedge clk);
    check("R8 hold", flagNzcv, 4'b0100);

    // R9: compare passes, loads flags, no destination write
    @(negedge clk);
    condCode = 4'h0; isCompare = 1; setFlags = 1; {aluN, aluZ, aluC, aluV} = 4'b0010;
    #1 check("R9 cmp execEn", execEn, 1);
    check("R9 cmp destWrite", destWrite, 0);
    @(posedge clk); #1 idle();
    @(negedge clk);
    check("R9 cmp flags", flagNzcv, 4'b0010);
    condCode = 4'h2; #1;
    check("R9 destWrite", destWrite, 1);

    // R10: sat on failing condition (EQ with Z=0) ignored
    step(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
    @(negedge clk);
    check("R10 fail no set", flagQ, 0);
    step(4'hE, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
    @(negedge clk);
    check("R10 set", flagQ, 1);
    loadFlags(4'b0000);
    @(negedge clk);
    check("R10 sticky", flagQ, 1);

    // R11: clear, then clear beats set
    step(4'hE, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0);
    @(negedge clk);
    check("R11 clear", flagQ, 0);
    step(4'hE, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
    step(4'hE, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0);
    @(negedge clk);
    check("R11 priority", flagQ, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule